// File: doc/BRIEF.md
# Dual-Buffer Page Program Sequencer

This block sits between a host and a slow, self-timed main memory array that is written one page at a time. It holds two independent page buffers. The host fills either buffer one byte at a time through a write port that advances a pointer for each buffer, and reads either buffer at any byte offset. A command port starts array work on a named buffer. A program command streams a run of bytes from that buffer into one array page and then starts the array's self-timed commit. A load command copies a whole array page into a buffer. The host can therefore stream data into one buffer while the array is still committing the other.

Loading a page, rewriting some of its bytes in the buffer and programming it back gives byte-level alteration of a page. The page size is picked at run time by `page_264_i`: 264 bytes when it is high and 256 bytes when it is low. The array holds 32,768 pages, so the page address is 15 bits wide. The array port is a simple strobe interface. `arr_busy_i` rises on the clock edge that samples `arr_start_o` and stays high until the commit is complete. Read data on `arr_rdata_i` is valid in the same cycle as `arr_rd_o`.

Top module: `pgbuf_seq`

## Requirements
- R1: While `rst_ni` is low and after reset, `busy_o`, `arr_wr_o`, `arr_rd_o` and `arr_start_o` are 0, and `cmd_ready_o` is 1.
- R2: Command op 3 (set pointer) sets the pointer of buffer `cmd_buf_i` to `cmd_off_i`, or to 0 when that offset is not below the page size. Each host write (`wr_valid_i`) stores `wr_data_i` at the selected buffer's pointer and advances the pointer. After the last byte of the page (263 when `page_264_i`=1, 255 when it is 0), the pointer wraps to byte 0 of the same buffer.
- R3: Command op 1 (program) streams `cmd_cnt_i` bytes of buffer `cmd_buf_i` to array page `cmd_page_i`, one `arr_wr_o` per cycle. The stream starts at byte `cmd_off_i`, and offsets wrap within the page. A count of 0, or a count above the page size, means a full page. Exactly one single-cycle `arr_start_o` follows the last byte, and each byte lands at the same offset in the array page.
- R4: `busy_o` rises the cycle after a program command is accepted. It stays high while `arr_busy_i` is high and falls only after `arr_busy_i` has been seen low.
- R5: While a program or load is in progress, a program (op 1) or load (op 2) command is stalled with `cmd_ready_o` low. This includes a program that names the buffer being committed. The command is accepted once the engine is idle. Op 0 (no operation) and op 3 are never stalled.
- R6: Host writes and reads of either buffer proceed while the array is programming. `rd_data_o` shows the byte at `rd_off_i` of buffer `rd_buf_i` in the same cycle.
- R7: Command op 2 (load) copies all page-size bytes of array page `cmd_page_i` into buffer `cmd_buf_i`, at offsets 0 upward, with one `arr_rd_o` per cycle.
- R8: A host write to the buffer that is being loaded is ignored and does not move that buffer's pointer.
- R9: Loading a page, rewriting some of its bytes and programming a full page back leaves every byte that was not rewritten unchanged in the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| page_264_i | input | 1 | Page size select: 1 = 264 bytes, 0 = 256 bytes |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command accepted this cycle when high with valid |
| cmd_op_i | input | 2 | 0 none, 1 program, 2 load, 3 set pointer |
| cmd_buf_i | input | 1 | Buffer targeted by the command |
| cmd_page_i | input | 15 | Array page address |
| cmd_off_i | input | 9 | Start byte for program or set pointer |
| cmd_cnt_i | input | 9 | Program byte count (0 = full page) |
| wr_valid_i | input | 1 | Host byte write strobe |
| wr_buf_i | input | 1 | Buffer written by the host |
| wr_data_i | input | 8 | Host write byte |
| rd_buf_i | input | 1 | Buffer read by the host |
| rd_off_i | input | 9 | Host read offset |
| rd_data_o | output | 8 | Host read byte |
| busy_o | output | 1 | An array program is in progress |
| arr_wr_o | output | 1 | Byte write strobe to the array page latch |
| arr_rd_o | output | 1 | Byte read strobe to the array |
| arr_start_o | output | 1 | Start the self-timed page commit |
| arr_page_o | output | 15 | Array page address |
| arr_off_o | output | 9 | Array byte offset |
| arr_wdata_o | output | 8 | Array write byte |
| arr_rdata_i | input | 8 | Array read byte, same cycle as arr_rd_o |
| arr_busy_i | input | 1 | Array commit in progress |

## Verification
The bench targets pointer wrap at both page sizes. A design that wrapped at a fixed size would write bytes past 255 in 256-byte mode or fold 264-byte pages early. It also drives program runs that start near the page end, single-byte runs and zero counts. An off-by-one in the count, or a failure to wrap the offset, shows up as a corrupted page image. While the array is committing, the bench writes into the other buffer and issues a program on the busy engine: a design without the stall would raise a second start during the commit. The read-modify-write flow includes a host write during a load. A design that let that write through, or moved the pointer, would misplace the next byte written.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef enum logic [1:0] {
    OP_NOP    = 2'd0,
    OP_PROG   = 2'd1,
    OP_LOAD   = 2'd2,
    OP_SETPTR = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_COMMIT,
    ST_WAIT,
    ST_LOAD
  } eng_st_e;
endpackage

// File: rtl/pgbuf_ram.sv
module pgbuf_ram #(
  parameter int DEPTH = 264,
  parameter int DW    = 8,
  parameter int AW    = 9
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] ra_addr_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [AW-1:0] rb_addr_i,
  output logic [DW-1:0] rb_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && (int'(waddr_i) < DEPTH)) mem_q[waddr_i] <= wdata_i;
  end

  assign ra_data_o = (int'(ra_addr_i) < DEPTH) ? mem_q[ra_addr_i] : '0;
  assign rb_data_o = (int'(rb_addr_i) < DEPTH) ? mem_q[rb_addr_i] : '0;
endmodule

// File: rtl/pgbuf_engine.sv
module pgbuf_engine
  import pgbuf_pkg::*;
#(
  parameter int OFF_W  = 9,
  parameter int PAGE_W = 15,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_prog_i,
  input  logic              start_load_i,
  input  logic              buf_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [OFF_W-1:0]  cnt_i,
  input  logic [OFF_W-1:0]  size_i,
  output logic              idle_o,
  output logic              busy_o,
  output logic              load_act_o,
  output logic              act_buf_o,
  output logic [OFF_W-1:0]  idx_o,
  input  logic [DW-1:0]     buf_rdata_i,
  output logic              eng_we_o,
  output logic [DW-1:0]     eng_wdata_o,
  output logic              arr_wr_o,
  output logic              arr_rd_o,
  output logic              arr_start_o,
  output logic [PAGE_W-1:0] arr_page_o,
  output logic [OFF_W-1:0]  arr_off_o,
  output logic [DW-1:0]     arr_wdata_o,
  input  logic [DW-1:0]     arr_rdata_i,
  input  logic              arr_busy_i
);
  eng_st_e           st_q;
  logic              buf_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  size_q, idx_q, left_q;
  logic [OFF_W-1:0]  idx_nxt;

  assign idx_nxt = (idx_q >= size_q - 1'b1) ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      buf_q  <= 1'b0;
      page_q <= '0;
      size_q <= '0;
      idx_q  <= '0;
      left_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_prog_i) begin
            buf_q  <= buf_i;
            page_q <= page_i;
            size_q <= size_i;
            idx_q  <= (off_i >= size_i) ? '0 : off_i;
            left_q <= (cnt_i == '0 || cnt_i > size_i) ? size_i : cnt_i;
            st_q   <= ST_XFER;
          end else if (start_load_i) begin
            buf_q  <= buf_i;
            page_q <= page_i;
            size_q <= size_i;
            idx_q  <= '0;
            left_q <= size_i;
            st_q   <= ST_LOAD;
          end
        end
        ST_XFER, ST_LOAD: begin
          idx_q  <= idx_nxt;
          left_q <= left_q - 1'b1;
          if (left_q == OFF_W'(1)) st_q <= (st_q == ST_XFER) ? ST_COMMIT : ST_IDLE;
        end
        ST_COMMIT: st_q <= ST_WAIT;
        ST_WAIT:   if (!arr_busy_i) st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o      = (st_q == ST_IDLE);
  assign busy_o      = (st_q == ST_XFER) || (st_q == ST_COMMIT) || (st_q == ST_WAIT);
  assign load_act_o  = (st_q == ST_LOAD);
  assign act_buf_o   = buf_q;
  assign idx_o       = idx_q;
  assign eng_we_o    = (st_q == ST_LOAD);
  assign eng_wdata_o = arr_rdata_i;
  assign arr_wr_o    = (st_q == ST_XFER);
  assign arr_rd_o    = (st_q == ST_LOAD);
  assign arr_start_o = (st_q == ST_COMMIT);
  assign arr_page_o  = page_q;
  assign arr_off_o   = idx_q;
  assign arr_wdata_o = buf_rdata_i;

  // R3
  start_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_start_o |-> (!arr_wr_o && !arr_rd_o));
  // R3
  off_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_wr_o || arr_rd_o) |-> (arr_off_o < size_q));
  // R3
  last_byte_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_wr_o && left_q == OFF_W'(1)) |=> arr_start_o);
  // R4
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_start_o |=> busy_o);
  // R4
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !$past(arr_busy_i));
endmodule

// File: rtl/pgbuf_seq.sv
module pgbuf_seq
  import pgbuf_pkg::*;
#(
  parameter int BIG_BYTES   = 264,
  parameter int SMALL_BYTES = 256,
  parameter int PAGE_W      = 15,
  parameter int DW          = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              page_264_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic              cmd_buf_i,
  input  logic [PAGE_W-1:0] cmd_page_i,
  input  logic [8:0]        cmd_off_i,
  input  logic [8:0]        cmd_cnt_i,
  input  logic              wr_valid_i,
  input  logic              wr_buf_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              rd_buf_i,
  input  logic [8:0]        rd_off_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              busy_o,
  output logic              arr_wr_o,
  output logic              arr_rd_o,
  output logic              arr_start_o,
  output logic [PAGE_W-1:0] arr_page_o,
  output logic [8:0]        arr_off_o,
  output logic [DW-1:0]     arr_wdata_o,
  input  logic [DW-1:0]     arr_rdata_i,
  input  logic              arr_busy_i
);
  localparam int OFF_W = 9;
  localparam int NBUF  = 2;
  localparam logic [OFF_W-1:0] SIZE_BIG   = OFF_W'(BIG_BYTES);
  localparam logic [OFF_W-1:0] SIZE_SMALL = OFF_W'(SMALL_BYTES);

  op_e              op;
  logic [OFF_W-1:0] size;
  logic             accept, arr_op, eng_idle, load_act, act_buf, eng_we;
  logic [OFF_W-1:0] eng_idx;
  logic [DW-1:0]    eng_wdata, eng_rdata;
  logic [DW-1:0]    ra_data [NBUF];
  logic [DW-1:0]    rb_data [NBUF];
  logic [OFF_W-1:0] ptr_q   [NBUF];

  assign op          = op_e'(cmd_op_i);
  assign size        = page_264_i ? SIZE_BIG : SIZE_SMALL;
  assign arr_op      = (op == OP_PROG) || (op == OP_LOAD);
  assign cmd_ready_o = !arr_op || eng_idle;
  assign accept      = cmd_valid_i && cmd_ready_o;

  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    localparam logic SEL = 1'(i);
    logic             host_we, set_hit, ram_we;
    logic [OFF_W-1:0] ram_waddr;
    logic [DW-1:0]    ram_wdata;

    assign set_hit = accept && (op == OP_SETPTR) && (cmd_buf_i == SEL);
    assign host_we = wr_valid_i && (wr_buf_i == SEL) && !(load_act && act_buf == SEL);
    assign ram_we    = (load_act && act_buf == SEL) ? eng_we : host_we;
    assign ram_waddr = (load_act && act_buf == SEL) ? eng_idx : ptr_q[i];
    assign ram_wdata = (load_act && act_buf == SEL) ? eng_wdata : wr_data_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ptr_q[i] <= '0;
      else if (set_hit) ptr_q[i] <= (cmd_off_i >= size) ? '0 : cmd_off_i;
      else if (host_we) ptr_q[i] <= (ptr_q[i] >= size - 1'b1) ? '0 : ptr_q[i] + 1'b1;
    end

    pgbuf_ram #(.DEPTH(BIG_BYTES), .DW(DW), .AW(OFF_W)) u_ram (
      .clk_i    (clk_i),
      .we_i     (ram_we),
      .waddr_i  (ram_waddr),
      .wdata_i  (ram_wdata),
      .ra_addr_i(eng_idx),
      .ra_data_o(ra_data[i]),
      .rb_addr_i(rd_off_i),
      .rb_data_o(rb_data[i])
    );

    // R2
    ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ptr_q[i] < SIZE_BIG);
    // R8
    load_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_valid_i && wr_buf_i == SEL && load_act && act_buf == SEL && !set_hit)
        |=> (ptr_q[i] == $past(ptr_q[i])));
  end

  assign eng_rdata = ra_data[act_buf];
  assign rd_data_o = rb_data[rd_buf_i];

  pgbuf_engine #(.OFF_W(OFF_W), .PAGE_W(PAGE_W), .DW(DW)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_prog_i(accept && op == OP_PROG),
    .start_load_i(accept && op == OP_LOAD),
    .buf_i       (cmd_buf_i),
    .page_i      (cmd_page_i),
    .off_i       (cmd_off_i),
    .cnt_i       (cmd_cnt_i),
    .size_i      (size),
    .idle_o      (eng_idle),
    .busy_o      (busy_o),
    .load_act_o  (load_act),
    .act_buf_o   (act_buf),
    .idx_o       (eng_idx),
    .buf_rdata_i (eng_rdata),
    .eng_we_o    (eng_we),
    .eng_wdata_o (eng_wdata),
    .arr_wr_o    (arr_wr_o),
    .arr_rd_o    (arr_rd_o),
    .arr_start_o (arr_start_o),
    .arr_page_o  (arr_page_o),
    .arr_off_o   (arr_off_o),
    .arr_wdata_o (arr_wdata_o),
    .arr_rdata_i (arr_rdata_i),
    .arr_busy_i  (arr_busy_i)
  );

  // R5
  prog_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && op == OP_PROG && busy_o) |-> !cmd_ready_o);
  // R4
  prog_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op == OP_PROG) |=> busy_o);
endmodule

// File: tb/pgbuf_seq_tb_top.sv
module pgbuf_seq_tb_top;
  localparam int PROG_CYC = 20;

  typedef struct packed {
    logic       b;
    logic       p264;
    logic [8:0] foff;
    logic [8:0] nfill;
    logic [1:0] pg;
    logic [8:0] poff;
    logic [8:0] pcnt;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 1'b1, 9'd0,   9'd264, 2'd0, 9'd0,   9'd0},
    '{1'b1, 1'b0, 9'd250, 9'd10,  2'd1, 9'd250, 9'd10},
    '{1'b0, 1'b1, 9'd260, 9'd8,   2'd3, 9'd260, 9'd8},
    '{1'b1, 1'b1, 9'd5,   9'd1,   2'd1, 9'd5,   9'd1}
  };

  logic clk_i = 0, rst_ni = 0;
  logic page_264 = 1, cmd_valid = 0, cmd_buf = 0, wr_valid = 0, wr_buf = 0, rd_buf = 0;
  logic [1:0] cmd_op = 0;
  logic [14:0] cmd_page = 0;
  logic [8:0] cmd_off = 0, cmd_cnt = 0, rd_off = 0;
  logic [7:0] wr_data = 0;
  logic cmd_ready_o, busy_o, arr_wr_o, arr_rd_o, arr_start_o;
  logic [14:0] arr_page_o;
  logic [8:0] arr_off_o;
  logic [7:0] arr_wdata_o, arr_rdata, rd_data_o;
  logic arr_busy;
  int bcnt;

  logic [7:0] am [4][264];
  logic [7:0] em [4][264];
  logic [7:0] mb [2][264];
  int mptr [2];
  int n_chk = 0, n_fail = 0, wr_cnt = 0, rd_cnt = 0, st_cnt = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pgbuf_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .page_264_i(page_264),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready_o), .cmd_op_i(cmd_op),
    .cmd_buf_i(cmd_buf), .cmd_page_i(cmd_page), .cmd_off_i(cmd_off), .cmd_cnt_i(cmd_cnt),
    .wr_valid_i(wr_valid), .wr_buf_i(wr_buf), .wr_data_i(wr_data),
    .rd_buf_i(rd_buf), .rd_off_i(rd_off), .rd_data_o(rd_data_o), .busy_o(busy_o),
    .arr_wr_o(arr_wr_o), .arr_rd_o(arr_rd_o), .arr_start_o(arr_start_o),
    .arr_page_o(arr_page_o), .arr_off_o(arr_off_o), .arr_wdata_o(arr_wdata_o),
    .arr_rdata_i(arr_rdata), .arr_busy_i(arr_busy)
  );

  // array model: busy from the edge that samples start, for PROG_CYC cycles
  assign arr_rdata = am[arr_page_o[1:0]][arr_off_o];
  assign arr_busy  = (bcnt != 0);
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bcnt <= 0;
    else if (arr_start_o) bcnt <= PROG_CYC;
    else if (bcnt != 0) bcnt <= bcnt - 1;
  end
  always @(posedge clk_i) begin
    if (arr_wr_o) am[arr_page_o[1:0]][arr_off_o] <= arr_wdata_o;
    if (arr_wr_o) wr_cnt++;
    if (arr_rd_o) rd_cnt++;
    if (arr_start_o) st_cnt++;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int psize();
    return page_264 ? 264 : 256;
  endfunction

  task automatic cmd(input logic [1:0] op, input logic b, input logic [14:0] pg,
                     input logic [8:0] off, input logic [8:0] cnt);
    @(negedge clk_i);
    cmd_valid = 1; cmd_op = op; cmd_buf = b; cmd_page = pg; cmd_off = off; cmd_cnt = cnt;
    #1;
    while (!cmd_ready_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i);
    cmd_valid = 0; cmd_op = 0;
    if (op == 2'd3) mptr[b] = (int'(off) >= psize()) ? 0 : int'(off);
  endtask

  task automatic wr_byte(input logic b, input logic [7:0] d, input bit model);
    @(negedge clk_i);
    wr_valid = 1; wr_buf = b; wr_data = d;
    @(negedge clk_i);
    wr_valid = 0;
    if (model) begin
      mb[b][mptr[b]] = d;
      mptr[b] = (mptr[b] >= psize() - 1) ? 0 : mptr[b] + 1;
    end
  endtask

  task automatic wait_eng();
    do @(negedge clk_i); while (busy_o || arr_rd_o);
  endtask

  task automatic cmp_page(int pg, string req);
    int mism = 0;
    for (int k = 0; k < 264; k++) if (am[pg][k] !== em[pg][k]) mism++;
    chk(mism == 0, req, $sformatf("page %0d mismatching bytes", pg), mism, 0);
  endtask

  task automatic rd_chk(logic b, int off, logic [7:0] exp, string req);
    rd_buf = b; rd_off = 9'(off); #1;
    chk(rd_data_o === exp, req, $sformatf("buf%0d[%0d]", b, off), rd_data_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int w0, s0, r0, viol, sz, cnt, off;
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 264; k++) begin am[p][k] = 8'h00; em[p][k] = 8'h00; end
    mptr[0] = 0; mptr[1] = 0;
    repeat (3) @(negedge clk_i);
    #1;
    // R1 reset state
    chk(busy_o === 0 && cmd_ready_o === 1 && arr_wr_o === 0 && arr_rd_o === 0 && arr_start_o === 0,
        "R1", "outputs in reset", {busy_o, cmd_ready_o, arr_wr_o, arr_rd_o, arr_start_o}, 5'b01000);
    rst_ni = 1;
    @(negedge clk_i); #1;
    chk(busy_o === 0 && cmd_ready_o === 1 && arr_start_o === 0, "R1", "outputs after reset",
        {busy_o, cmd_ready_o, arr_start_o}, 3'b010);

    // table of fill/program vectors: R2 wrap, R3 counts and offsets
    foreach (VECS[v]) begin
      page_264 = VECS[v].p264;
      sz = psize();
      cmd(2'd3, VECS[v].b, 15'd0, VECS[v].foff, 9'd0);
      for (int k = 0; k < int'(VECS[v].nfill); k++) wr_byte(VECS[v].b, 8'(k * 13 + v * 29 + 3), 1);
      cnt = (VECS[v].pcnt == 0 || int'(VECS[v].pcnt) > sz) ? sz : int'(VECS[v].pcnt);
      off = (int'(VECS[v].poff) >= sz) ? 0 : int'(VECS[v].poff);
      for (int k = 0; k < cnt; k++) em[VECS[v].pg][(off + k) % sz] = mb[VECS[v].b][(off + k) % sz];
      w0 = wr_cnt; s0 = st_cnt;
      cmd(2'd1, VECS[v].b, {13'd0, VECS[v].pg}, VECS[v].poff, VECS[v].pcnt);
      wait_eng();
      chk(wr_cnt - w0 == cnt, "R3", "array byte writes", wr_cnt - w0, cnt);
      chk(st_cnt - s0 == 1, "R3", "commit starts", st_cnt - s0, 1);
      cmp_page(VECS[v].pg, "R3");
    end

    // R2 wrap at 264 and at 256, out-of-range pointer set
    page_264 = 1;
    cmd(2'd3, 1'b0, 15'd0, 9'd262, 9'd0);
    for (int k = 0; k < 4; k++) wr_byte(1'b0, 8'hD0 + 8'(k), 1);
    rd_chk(0, 262, 8'hD0, "R2"); rd_chk(0, 263, 8'hD1, "R2");
    rd_chk(0, 0, 8'hD2, "R2");   rd_chk(0, 1, 8'hD3, "R2");
    page_264 = 0;
    cmd(2'd3, 1'b1, 15'd0, 9'd255, 9'd0);
    wr_byte(1'b1, 8'h71, 1); wr_byte(1'b1, 8'h72, 1);
    rd_chk(1, 255, 8'h71, "R2"); rd_chk(1, 0, 8'h72, "R2");
    cmd(2'd3, 1'b1, 15'd0, 9'd260, 9'd0);
    wr_byte(1'b1, 8'hE5, 1);
    rd_chk(1, 0, 8'hE5, "R2");

    // R4 R5 R6: program buf0, overlap buf1 intake, stalled second program
    page_264 = 1;
    cmd(2'd3, 1'b0, 15'd0, 9'd0, 9'd0);
    for (int k = 0; k < 4; k++) wr_byte(1'b0, 8'h10 + 8'(k), 1);
    for (int k = 0; k < 4; k++) em[3][k] = 8'h10 + 8'(k);
    s0 = st_cnt;
    cmd(2'd1, 1'b0, 15'd3, 9'd0, 9'd4);
    while (!arr_busy) @(negedge clk_i);
    #1;
    chk(busy_o === 1, "R4", "busy during commit", busy_o, 1);
    cmd(2'd3, 1'b1, 15'd0, 9'd40, 9'd0);
    for (int k = 0; k < 3; k++) wr_byte(1'b1, 8'hC0 + 8'(k), 1);
    for (int k = 0; k < 3; k++) em[3][40 + k] = 8'hC0 + 8'(k);
    chk(arr_busy === 1, "R6", "intake overlapped commit", arr_busy, 1);
    rd_chk(1, 40, 8'hC0, "R6"); rd_chk(1, 42, 8'hC2, "R6");
    @(negedge clk_i);
    cmd_valid = 1; cmd_op = 2'd1; cmd_buf = 1; cmd_page = 15'd3; cmd_off = 9'd40; cmd_cnt = 9'd3;
    #1;
    chk(cmd_ready_o === 0, "R5", "program stalled while busy", cmd_ready_o, 0);
    cmd_op = 2'd1; cmd_buf = 0; #1;
    chk(cmd_ready_o === 0, "R5", "same-buffer program stalled", cmd_ready_o, 0);
    cmd_op = 2'd3; #1;
    chk(cmd_ready_o === 1, "R5", "set pointer not stalled", cmd_ready_o, 1);
    cmd_valid = 0; cmd_op = 2'd1; cmd_buf = 1; cmd_valid = 1; #1;
    viol = 0;
    while (!cmd_ready_o) begin
      if (arr_busy && !busy_o) viol++;
      @(negedge clk_i); #1;
    end
    chk(viol == 0, "R4", "busy low while array busy", viol, 0);
    chk(busy_o === 0 && arr_busy === 0, "R5", "accepted only after commit", {busy_o, arr_busy}, 0);
    @(negedge clk_i);
    cmd_valid = 0; cmd_op = 0;
    wait_eng();
    chk(st_cnt - s0 == 2, "R5", "one start per program", st_cnt - s0, 2);
    cmp_page(3, "R5");
    #1;
    chk(busy_o === 0, "R4", "busy released", busy_o, 0);

    // R7 R8 R9: read-modify-write of page 2
    for (int k = 0; k < 264; k++) begin am[2][k] = 8'(k) ^ 8'h5A; em[2][k] = 8'(k) ^ 8'h5A; end
    cmd(2'd3, 1'b1, 15'd0, 9'd20, 9'd0);
    r0 = rd_cnt;
    cmd(2'd2, 1'b1, 15'd2, 9'd0, 9'd0);
    wr_byte(1'b1, 8'hEE, 0);
    wait_eng();
    chk(rd_cnt - r0 == 264, "R7", "array byte reads", rd_cnt - r0, 264);
    viol = 0;
    for (int k = 0; k < 264; k++) begin
      rd_buf = 1; rd_off = 9'(k); #1;
      if (rd_data_o !== (8'(k) ^ 8'h5A)) viol++;
    end
    chk(viol == 0, "R7", "loaded bytes mismatching", viol, 0);
    wr_byte(1'b1, 8'h11, 0);
    rd_chk(1, 20, 8'h11, "R8");
    rd_chk(1, 21, 8'd21 ^ 8'h5A, "R8");
    em[2][20] = 8'h11;
    mptr[1] = 21;
    cmd(2'd3, 1'b1, 15'd0, 9'd100, 9'd0);
    for (int k = 0; k < 3; k++) begin wr_byte(1'b1, 8'hA1 + 8'(k), 1); em[2][100 + k] = 8'hA1 + 8'(k); end
    cmd(2'd1, 1'b1, 15'd2, 9'd0, 9'd0);
    wait_eng();
    cmp_page(2, "R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule